// File: doc/BRIEF.md
# Serial Memory Power-State Sequencer

This block holds the power state of a serial memory slave in the system clock domain. When the power-good reset is released it holds off all access for a fixed start-up lockout. It then reports ready, and it carries out sleep and wake requests that the slave's command engine passes to it as one-cycle strobes. A strobe only takes effect when the chip select returns to its inactive (high) level, which is the point where the command byte has ended. Sleep drops the regulator enable at once and then waits out a short settling window before the memory counts as asleep. Wake raises the enable again and starts a long recovery lockout. During that lockout, as during start-up, chip select must stay high.

Every duration is given in nanoseconds together with the clock frequency in kHz. The block converts each one to a cycle count, rounded up and never less than one. An access attempted during a lockout raises a violation flag and is otherwise dropped. The ready output gates command acceptance in the slave engine. The regulator enable drives the memory's internal supplies.

Top module: `mem_pwr_sequencer`

## Requirements
- R1: While reset is asserted, ready_o is 0, reg_en_o is 1 and lock_viol_o is 0.
- R2: Each duration in cycles is ceil(ns * CLK_KHZ / 1e6), with a minimum of 1. ready_o first reads 1 after the PU_CYC-th rising clock edge that follows reset release, and is 0 before that edge.
- R3: A sleep strobe accepted in the ready state takes effect on the first clock edge that samples cs_ni high after it was low. From that edge ready_o and reg_en_o are both 0.
- R4: A strobe alone changes nothing while cs_ni stays low. ready_o stays 1 until the CS rising edge is sampled.
- R5: After sleep takes effect at edge E0, any command whose CS rise is sampled at an edge up to E0+ENTER_CYC is ignored. A wake whose rise is sampled at E0+ENTER_CYC+1 or later is accepted.
- R6: While asleep, a sleep command is ignored: reg_en_o and ready_o stay 0.
- R7: A wake accepted while asleep sets reg_en_o to 1 from its CS-rise edge W0. ready_o reads 1 from edge W0+RESUME_CYC on and is 0 before that.
- R8: A wake command received in the ready state has no effect: ready_o and reg_en_o stay 1.
- R9: When cs_ni is sampled low at a clock edge during the start-up or wake lockout, lock_viol_o reads 1 after that edge. It reads 0 after an edge that samples cs_ni high. The lockout length is unchanged, and strobes given during the lockout are discarded.
- R10: cs_ni low in the ready state does not raise lock_viol_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-good reset, active low, asynchronous |
| cs_ni | input | 1 | Chip select level, active low |
| sleep_stb_i | input | 1 | One-cycle sleep command strobe from the command engine |
| wake_stb_i | input | 1 | One-cycle wake command strobe from the command engine |
| ready_o | output | 1 | High only in the ready (standby) state |
| reg_en_o | output | 1 | Regulator enable, low during sleep entry and sleep |
| lock_viol_o | output | 1 | High for each cycle CS was sampled low during a lockout |

## Verification
A state register stuck in a lockout state shows up as ready_o staying low past its computed edge. A timer loaded off by one moves the ready edge or the wake-acceptance boundary by exactly one cycle. A command latch that acts on the strobe instead of the CS rise makes ready_o or reg_en_o move one or more cycles early. The bench samples these edges cycle by cycle, so such errors show within the lockout window in which they occur. A guard that misreads the state raises lock_viol_o in standby, or fails to raise it one cycle after CS drops during a lockout.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PS_POWERUP     = 3'd0,
    PS_STANDBY     = 3'd1,
    PS_SLEEP_ENTER = 3'd2,
    PS_SLEEP       = 3'd3,
    PS_WAKING      = 3'd4
  } pstate_t;

  // ceil(ns * khz / 1e6), never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = 64'(ns) * 64'(khz);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic is_lockout(input pstate_t s);
    return (s == PS_POWERUP) || (s == PS_WAKING);
  endfunction

endpackage

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CW'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2/R5/R7: the counter walks down by exactly one each idle cycle
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r5_load_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/pmc_cmd_latch.sv
module pmc_cmd_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sleep_stb_i,
  input  logic wake_stb_i,
  input  logic capture_en_i,
  output logic do_sleep_o,
  output logic do_wake_o
);

  logic cs_q;
  logic pend_sleep_q, pend_wake_q;
  logic cs_rise;
  logic sleep_seen, wake_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end

  assign cs_rise    = cs_ni && !cs_q;
  assign sleep_seen = pend_sleep_q || (sleep_stb_i && capture_en_i);
  assign wake_seen  = pend_wake_q  || (wake_stb_i  && capture_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_sleep_q <= 1'b0;
      pend_wake_q  <= 1'b0;
    end else if (!capture_en_i || cs_rise) begin
      pend_sleep_q <= 1'b0;
      pend_wake_q  <= 1'b0;
    end else begin
      pend_sleep_q <= sleep_seen;
      pend_wake_q  <= wake_seen;
    end
  end

  assign do_sleep_o = cs_rise && sleep_seen;
  assign do_wake_o  = cs_rise && wake_seen;

  // R4: a command acts only at a sampled CS low-to-high change
  a_r4_act_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_sleep_o || do_wake_o) |-> (cs_ni && !$past(cs_ni)));

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    expired_i,
  input  logic    do_sleep_i,
  input  logic    do_wake_i,
  output pstate_t state_o,
  output logic    load_entry_o,
  output logic    load_wake_o
);

  pstate_t state_q, state_d;

  always_comb begin
    state_d      = state_q;
    load_entry_o = 1'b0;
    load_wake_o  = 1'b0;
    unique case (state_q)
      PS_POWERUP:     if (expired_i) state_d = PS_STANDBY;
      PS_STANDBY:     if (do_sleep_i) begin
                        state_d      = PS_SLEEP_ENTER;
                        load_entry_o = 1'b1;
                      end
      PS_SLEEP_ENTER: if (expired_i) state_d = PS_SLEEP;
      PS_SLEEP:       if (do_wake_i) begin
                        state_d     = PS_WAKING;
                        load_wake_o = 1'b1;
                      end
      PS_WAKING:      if (expired_i) state_d = PS_STANDBY;
      default:        state_d = PS_POWERUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_POWERUP;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R3: the entry window is only ever entered from standby
  a_r3_entry_from_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP_ENTER && $past(state_q) != PS_SLEEP_ENTER)
      |-> ($past(state_q) == PS_STANDBY));

  // R6: sleep persists until a wake arrives
  a_r6_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP && !do_wake_i) |=> (state_q == PS_SLEEP));

  // R2/R7: standby is reached only after a timer ran out
  a_r2_standby_after_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STANDBY && $past(state_q) != PS_STANDBY) |-> $past(expired_i));

  a_r5_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_entry_o, load_wake_o}));

endmodule

// File: rtl/pmc_guard.sv
module pmc_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic locked_i,
  input  logic cs_ni,
  output logic viol_o
);

  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= locked_i && !cs_ni;
  end

  assign viol_o = viol_q;

  // R9/R10: the flag points back at a lockout cycle with CS low
  a_r9_viol_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |-> ($past(locked_i) && !$past(cs_ni)));

  a_r10_quiet_when_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(locked_i) |-> !viol_q);

endmodule

// File: rtl/mem_pwr_sequencer.sv
module mem_pwr_sequencer
  import pmc_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50_000,
  parameter int unsigned PU_NS     = 400_000,
  parameter int unsigned ENTER_NS  = 3_000,
  parameter int unsigned RESUME_NS = 400_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sleep_stb_i,
  input  logic wake_stb_i,
  output logic ready_o,
  output logic reg_en_o,
  output logic lock_viol_o
);

  localparam int unsigned PU_CYC     = ns_to_cycles(PU_NS, CLK_KHZ);
  localparam int unsigned ENTER_CYC  = ns_to_cycles(ENTER_NS, CLK_KHZ);
  localparam int unsigned RESUME_CYC = ns_to_cycles(RESUME_NS, CLK_KHZ);
  localparam int unsigned MAX_CYC    = max3(PU_CYC, ENTER_CYC, RESUME_CYC);
  localparam int unsigned CW         = $clog2(MAX_CYC + 1);

  pstate_t       state;
  logic          expired;
  logic          load_entry, load_wake, load_any;
  logic [CW-1:0] load_val;
  logic          do_sleep, do_wake;
  logic          locked, capture_en;

  assign locked     = is_lockout(state);
  assign capture_en = !locked;

  pmc_cmd_latch u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .sleep_stb_i  (sleep_stb_i),
    .wake_stb_i   (wake_stb_i),
    .capture_en_i (capture_en),
    .do_sleep_o   (do_sleep),
    .do_wake_o    (do_wake)
  );

  pmc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expired_i    (expired),
    .do_sleep_i   (do_sleep),
    .do_wake_i    (do_wake),
    .state_o      (state),
    .load_entry_o (load_entry),
    .load_wake_o  (load_wake)
  );

  assign load_any = load_entry || load_wake;
  assign load_val = load_entry ? CW'(ENTER_CYC - 1) : CW'(RESUME_CYC - 1);

  pmc_timer #(
    .CW      (CW),
    .RST_VAL (PU_CYC - 1)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_any),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  pmc_guard u_grd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .locked_i (locked),
    .cs_ni    (cs_ni),
    .viol_o   (lock_viol_o)
  );

  assign ready_o  = (state == PS_STANDBY);
  assign reg_en_o = !((state == PS_SLEEP_ENTER) || (state == PS_SLEEP));

  // R3: regulators off implies not ready
  a_r3_off_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_o |-> !ready_o);

  // R7: ready never rises straight out of a regulator-off state
  a_r7_ready_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(locked));

  // R8: a lone wake in standby keeps the block ready
  a_r8_wake_in_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && do_wake && !do_sleep) |=> ready_o);

endmodule

// File: tb/sim_mem_pwr_sequencer.sv
`timescale 1ns/1ps
module sim_mem_pwr_sequencer;

  localparam int CLK_P     = 10;
  localparam int KHZ       = 100_000;
  localparam int PU_NS     = 250;
  localparam int ENTER_NS  = 55;
  localparam int RESUME_NS = 200;

  function automatic int exp_cycles(input int ns, input int khz);
    longint p;
    longint q;
    p = longint'(ns) * longint'(khz);
    q = p / 1_000_000;
    if (q * 1_000_000 != p) q = q + 1;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  localparam int PU = exp_cycles(PU_NS, KHZ);
  localparam int EN = exp_cycles(ENTER_NS, KHZ);
  localparam int RS = exp_cycles(RESUME_NS, KHZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic slp = 1'b0;
  logic wak = 1'b0;
  logic ready, reg_en, viol;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_pwr_sequencer #(
    .CLK_KHZ(KHZ), .PU_NS(PU_NS), .ENTER_NS(ENTER_NS), .RESUME_NS(RESUME_NS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sleep_stb_i(slp),
    .wake_stb_i(wak), .ready_o(ready), .reg_en_o(reg_en), .lock_viol_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // ends right after the edge that samples the CS rise
  task automatic txn(input logic s, input logic w);
    cs_n = 1'b0; step();
    slp = s; wak = w; step();
    slp = 1'b0; wak = 1'b0; cs_n = 1'b1; step();
  endtask

  task automatic wake_wait(input string req);
    for (int k = 1; k <= RS; k++) begin
      step();
      chk(req, ready, (k >= RS) ? 1 : 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50_000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset values
    step(); step();
    chk("R1 ready", ready, 0);
    chk("R1 reg_en", reg_en, 1);
    chk("R1 viol", viol, 0);
    chk("R2 cycle calc", PU * 1_000_000 >= PU_NS * KHZ ? 1 : 0, 1);
    chk("R2 entry rounds up", EN, 6);

    // R2 start-up lockout, exact edge
    rst_n = 1'b1;
    for (int k = 1; k <= PU + 2; k++) begin
      step();
      chk("R2 powerup ready", ready, (k >= PU) ? 1 : 0);
    end

    // R8 wake in standby, R10 no violation while open
    cs_n = 1'b0; step();
    chk("R10 viol in standby", viol, 0);
    wak = 1'b1; step(); wak = 1'b0; cs_n = 1'b1; step();
    for (int k = 0; k < 4; k++) begin
      chk("R8 ready kept", ready, 1);
      chk("R8 reg_en kept", reg_en, 1);
      step();
    end

    // R4 strobe held back until CS rises, R3 acting at the rise
    cs_n = 1'b0; step();
    slp = 1'b1; step(); slp = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 ready while CS low", ready, 1);
    end
    cs_n = 1'b1; step();
    chk("R3 ready off", ready, 0);
    chk("R3 reg_en off", reg_en, 0);
    for (int k = 0; k < EN + 2; k++) step();

    // R6 sleep while asleep ignored
    txn(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk("R6 reg_en stays off", reg_en, 0);
      chk("R6 ready stays off", ready, 0);
      step();
    end
    txn(1'b0, 1'b1);
    chk("R7 reg_en on at rise", reg_en, 1);
    wake_wait("R7 resume ready");

    // R5 sweep of the wake rise edge across the entry window
    for (int d = 3; d <= EN + 2; d++) begin
      txn(1'b1, 1'b0);
      chk("R3 sleep taken", reg_en, 0);
      for (int k = 0; k < d - 3; k++) step();
      txn(1'b0, 1'b1);
      chk("R5 wake at entry offset", reg_en, (d >= EN + 1) ? 1 : 0);
      if (reg_en) begin
        wake_wait("R7 resume after entry");
      end else begin
        for (int k = 0; k < EN + 2; k++) step();
        chk("R5 still asleep", reg_en, 0);
        txn(1'b0, 1'b1);
        wake_wait("R7 resume after ignore");
      end
    end

    // R9 violation during wake lockout
    txn(1'b1, 1'b0);
    for (int k = 0; k < EN + 2; k++) step();
    txn(1'b0, 1'b1);
    cs_n = 1'b0; step();
    chk("R9 viol raised", viol, 1);
    slp = 1'b1; step();
    chk("R9 viol held", viol, 1);
    slp = 1'b0; cs_n = 1'b1; step();
    chk("R9 viol cleared", viol, 0);
    for (int k = 4; k < RS; k++) step();
    chk("R9 lockout not extended (before)", ready, 0);
    step();
    chk("R9 lockout not extended (edge)", ready, 1);
    for (int k = 0; k < EN + 3; k++) begin
      step();
      chk("R9 dropped sleep", reg_en, 1);
    end

    // R9 violation during start-up lockout
    rst_n = 1'b0; step();
    chk("R1 reset again", ready, 0);
    rst_n = 1'b1; cs_n = 1'b0; step();
    chk("R9 powerup viol", viol, 1);
    cs_n = 1'b1; step();
    chk("R9 powerup viol clear", viol, 0);
    for (int k = 3; k < PU; k++) step();
    chk("R2 powerup edge-1", ready, 0);
    step();
    chk("R2 powerup edge", ready, 1);

    finish_run();
  end

endmodule